// File: doc/BRIEF.md
# Tile/Detile Copy Sequencer

This block copies one image between a linear buffer and a tiled buffer, one pixel at a time. After a start pulse it walks the image in raster order, rows on the outside and columns on the inside. For every pixel it sends a linear address to an attached address translator and waits for the tiled address. If the tiled address falls inside the tile region, it reads the pixel from the source buffer and writes it to the destination buffer. It uses two simple synchronous memory ports, one for each buffer. The read data on either port appears one cycle after the read strobe.

A mode input sets the direction. Encode (mode 0) copies linear to tiled, and decode (mode 1) copies tiled to linear. A pixel is either 2 or 4 bytes wide. A pixel whose tiled address lies outside the region is dropped silently, and the walk continues with the next pixel.

The controller is a five-state machine:
- IDLE waits for start. It leaves to FINISH when the image is empty and to XLAT otherwise.
- XLAT holds the translator request until it is acknowledged. From there it goes to READ for an in-range pixel. For an out-of-range pixel it goes back to XLAT, or to FINISH if that was the last pixel.
- READ always goes to WRITE.
- WRITE goes to XLAT, or to FINISH after the last pixel.
- FINISH pulses done and returns to IDLE.

Top module: `tile_copy_seq`

## Requirements
- R1: Pixels are visited in raster order, with column innermost. Each translator request carries base + data_offset + row×pitch + col×bytes_per_pixel. There is exactly one acknowledged request per pixel.
- R2: With mode 0, each in-range pixel is read from the linear port at row×pitch + col×bytes_per_pixel and written one cycle later to the tiled port. The linear buffer is never written.
- R3: With mode 1, each in-range pixel is read from the tiled port and written one cycle later to the linear port at row×pitch + col×bytes_per_pixel. The tiled buffer is never written.
- R4: Every strobe uses byte-enable 4'b0011 when px_wide is 0 (2 bytes) and 4'b1111 when px_wide is 1 (4 bytes). Byte lane k carries byte address+k.
- R5: When (tiled − tile_base) ≥ tile_size, the pixel causes no read and no write on either port.
- R6: The tiled-port address is (tiled − tile_base) − data_offset, using modulo 2^AW arithmetic.
- R7: After reset, busy, done, the request and all strobes are low. done is high for exactly one cycle, in the cycle after the last pixel's write or skip. busy falls in the following cycle.
- R8: All configuration inputs are captured at start. A start pulse, or any change to the inputs, while busy has no effect on the copy in progress.
- R9: A start with width or height equal to zero raises done in the next cycle. It issues no request and no memory access.
- R10: Once raised, the translator request stays high until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a copy when idle |
| mode | input | 1 | 0 encode (linear to tiled), 1 decode (tiled to linear) |
| img_width | input | DIM_W | Pixels per row |
| img_height | input | DIM_W | Rows |
| pitch | input | PITCH_W | Bytes between row starts in the linear buffer |
| px_wide | input | 1 | 0: 2-byte pixels, 1: 4-byte pixels |
| tile_base | input | AW | Base address of the tile region |
| tile_size | input | AW | Size of the tile region in bytes |
| data_offset | input | AW | Offset of the data inside the tile region |
| xl_req | output | 1 | Translation request |
| xl_addr | output | AW | Linear address to translate |
| xl_ack | input | 1 | Translation result valid |
| xl_tiled | input | AW | Translated tiled address |
| lin_en | output | 1 | Linear port strobe |
| lin_we | output | 1 | Linear port write |
| lin_addr | output | AW | Linear port byte address |
| lin_be | output | 4 | Linear port byte enables |
| lin_wdata | output | 32 | Linear port write data |
| lin_rdata | input | 32 | Linear port read data (one-cycle latency) |
| til_en | output | 1 | Tiled port strobe |
| til_we | output | 1 | Tiled port write |
| til_addr | output | AW | Tiled port byte address |
| til_be | output | 4 | Tiled port byte enables |
| til_wdata | output | 32 | Tiled port write data |
| til_rdata | input | 32 | Tiled port read data (one-cycle latency) |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random images are copied in both directions. Width, height, pitch padding, pixel size and data offset are all varied. A bench translator with a bijective swizzle and a random 0–2 cycle latency supplies the tiled addresses.

Random region sizes mix in-range and out-of-range pixels, so wrong bounds tests show up as wrong write counts and wrong memory images. A region size of zero forces every pixel to be skipped. The 1×1 image and the zero-width and zero-height images separate the last-pixel and empty-image paths. A start pulse with altered inputs in the middle of a run shows whether the captured configuration is really held.

// File: rtl/tcs_pkg.sv
`timescale 1ns/1ps
package tcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XLAT,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } tcs_state_e;

    localparam int  PIX_BYTES_MAX = 4;
    localparam logic MODE_ENCODE  = 1'b0;
    localparam logic MODE_DECODE  = 1'b1;

    function automatic logic [PIX_BYTES_MAX-1:0] pix_mask(input logic wide);
        return wide ? 4'b1111 : 4'b0011;
    endfunction

endpackage

// File: rtl/tcs_walker.sv
`timescale 1ns/1ps
module tcs_walker #(
    parameter int AW      = 32,
    parameter int DIM_W   = 16,
    parameter int PITCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [DIM_W-1:0]   width,
    input  logic [DIM_W-1:0]   height,
    input  logic [PITCH_W-1:0] pitch,
    input  logic               wide,
    output logic [AW-1:0]      lin_off,
    output logic               last
);

    logic [DIM_W-1:0] col_q, row_q;
    logic [AW-1:0]    row_base_q, col_off_q;
    logic             col_end;

    assign col_end = (col_q == width - DIM_W'(1));
    assign last    = col_end && (row_q == height - DIM_W'(1));
    assign lin_off = row_base_q + col_off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q      <= '0;
            row_q      <= '0;
            row_base_q <= '0;
            col_off_q  <= '0;
        end else if (load) begin
            col_q      <= '0;
            row_q      <= '0;
            row_base_q <= '0;
            col_off_q  <= '0;
        end else if (step) begin
            if (col_end) begin
                col_q      <= '0;
                col_off_q  <= '0;
                row_q      <= row_q + DIM_W'(1);
                row_base_q <= row_base_q + AW'(pitch);
            end else begin
                col_q     <= col_q + DIM_W'(1);
                col_off_q <= col_off_q + (wide ? AW'(4) : AW'(2));
            end
        end
    end

    // R1: the walk never steps past the image boundary
    p_walk_in_image_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (col_q < width) && (row_q < height));

endmodule

// File: rtl/tcs_bounds.sv
`timescale 1ns/1ps
module tcs_bounds #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] tiled,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    input  logic [AW-1:0] doff,
    output logic          oob,
    output logic [AW-1:0] toff
);

    logic [AW-1:0] rel;

    always_comb begin
        rel  = tiled - base;
        oob  = (rel >= size);
        toff = rel - doff;
    end

endmodule

// File: rtl/tcs_port_mux.sv
`timescale 1ns/1ps
module tcs_port_mux #(
    parameter int AW   = 32,
    parameter int BE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              rd,
    input  logic              wr,
    input  logic [AW-1:0]     lin_off,
    input  logic [AW-1:0]     toff,
    input  logic [BE_W-1:0]   be,
    input  logic [8*BE_W-1:0] lin_rdata,
    input  logic [8*BE_W-1:0] til_rdata,
    output logic              lin_en,
    output logic              lin_we,
    output logic [AW-1:0]     lin_addr,
    output logic [BE_W-1:0]   lin_be,
    output logic [8*BE_W-1:0] lin_wdata,
    output logic              til_en,
    output logic              til_we,
    output logic [AW-1:0]     til_addr,
    output logic [BE_W-1:0]   til_be,
    output logic [8*BE_W-1:0] til_wdata
);

    always_comb begin
        lin_addr  = lin_off;
        til_addr  = toff;
        lin_be    = be;
        til_be    = be;
        lin_wdata = til_rdata;
        til_wdata = lin_rdata;
        if (mode == tcs_pkg::MODE_ENCODE) begin
            lin_en = rd;
            lin_we = 1'b0;
            til_en = wr;
            til_we = wr;
        end else begin
            til_en = rd;
            til_we = 1'b0;
            lin_en = wr;
            lin_we = wr;
        end
    end

    // R2/R3: at most one buffer is written in a cycle
    p_single_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lin_en && lin_we, til_en && til_we}));

    // R3: a decode run never writes the tiled buffer
    p_decode_no_tiled_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == tcs_pkg::MODE_DECODE) |-> !(til_en && til_we));

endmodule

// File: rtl/tile_copy_seq.sv
`timescale 1ns/1ps
module tile_copy_seq
    import tcs_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DIM_W   = 16,
    parameter int PITCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode,
    input  logic [DIM_W-1:0]   img_width,
    input  logic [DIM_W-1:0]   img_height,
    input  logic [PITCH_W-1:0] pitch,
    input  logic               px_wide,
    input  logic [AW-1:0]      tile_base,
    input  logic [AW-1:0]      tile_size,
    input  logic [AW-1:0]      data_offset,
    output logic               xl_req,
    output logic [AW-1:0]      xl_addr,
    input  logic               xl_ack,
    input  logic [AW-1:0]      xl_tiled,
    output logic               lin_en,
    output logic               lin_we,
    output logic [AW-1:0]      lin_addr,
    output logic [3:0]         lin_be,
    output logic [31:0]        lin_wdata,
    input  logic [31:0]        lin_rdata,
    output logic               til_en,
    output logic               til_we,
    output logic [AW-1:0]      til_addr,
    output logic [3:0]         til_be,
    output logic [31:0]        til_wdata,
    input  logic [31:0]        til_rdata,
    output logic               busy,
    output logic               done
);

    localparam int BE_W = PIX_BYTES_MAX;

    tcs_state_e state_q, state_d;

    logic               mode_q, wide_q;
    logic [DIM_W-1:0]   width_q, height_q;
    logic [PITCH_W-1:0] pitch_q;
    logic [AW-1:0]      base_q, size_q, doff_q, toff_q;

    logic          load, step, rd, wr, last, oob, empty;
    logic [AW-1:0] lin_off, toff;
    logic [BE_W-1:0] be;

    assign empty = (img_width == '0) || (img_height == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = empty ? ST_FINISH : ST_XLAT;
            ST_XLAT:   if (xl_ack) begin
                           if (!oob)     state_d = ST_READ;
                           else if (last) state_d = ST_FINISH;
                           else          state_d = ST_XLAT;
                       end
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = last ? ST_FINISH : ST_XLAT;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and control strobes
    always_comb begin
        xl_req = (state_q == ST_XLAT);
        rd     = (state_q == ST_READ);
        wr     = (state_q == ST_WRITE);
        done   = (state_q == ST_FINISH);
        busy   = (state_q != ST_IDLE);
        load   = (state_q == ST_IDLE) && start;
        step   = ((state_q == ST_XLAT) && xl_ack && oob) || (state_q == ST_WRITE);
    end

    // Configuration capture and tiled offset hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_ENCODE;
            wide_q   <= 1'b0;
            width_q  <= '0;
            height_q <= '0;
            pitch_q  <= '0;
            base_q   <= '0;
            size_q   <= '0;
            doff_q   <= '0;
            toff_q   <= '0;
        end else begin
            if (load) begin
                mode_q   <= mode;
                wide_q   <= px_wide;
                width_q  <= img_width;
                height_q <= img_height;
                pitch_q  <= pitch;
                base_q   <= tile_base;
                size_q   <= tile_size;
                doff_q   <= data_offset;
            end
            if ((state_q == ST_XLAT) && xl_ack) toff_q <= toff;
        end
    end

    assign xl_addr = base_q + doff_q + lin_off;
    assign be      = pix_mask(wide_q);

    tcs_walker #(.AW(AW), .DIM_W(DIM_W), .PITCH_W(PITCH_W)) u_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .width   (width_q),
        .height  (height_q),
        .pitch   (pitch_q),
        .wide    (wide_q),
        .lin_off (lin_off),
        .last    (last)
    );

    tcs_bounds #(.AW(AW)) u_bounds (
        .tiled (xl_tiled),
        .base  (base_q),
        .size  (size_q),
        .doff  (doff_q),
        .oob   (oob),
        .toff  (toff)
    );

    tcs_port_mux #(.AW(AW), .BE_W(BE_W)) u_port_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .rd        (rd),
        .wr        (wr),
        .lin_off   (lin_off),
        .toff      (toff_q),
        .be        (be),
        .lin_rdata (lin_rdata),
        .til_rdata (til_rdata),
        .lin_en    (lin_en),
        .lin_we    (lin_we),
        .lin_addr  (lin_addr),
        .lin_be    (lin_be),
        .lin_wdata (lin_wdata),
        .til_en    (til_en),
        .til_we    (til_we),
        .til_addr  (til_addr),
        .til_be    (til_be),
        .til_wdata (til_wdata)
    );

    // R7: done lasts a single cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: request held until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !xl_ack) |=> xl_req);

    // R9: empty image finishes next cycle without touching anything
    p_empty_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && empty) |=> (done && !xl_req && !lin_en && !til_en));

    // R5: out-of-range pixel produces no memory strobe
    p_oob_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && xl_ack && oob) |=> !(lin_en || til_en));

    // R2: every write follows a read on the other port
    p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((lin_en && lin_we) || (til_en && til_we)) |->
            $past((lin_en && !lin_we) || (til_en && !til_we)));

    // R8: captured configuration cannot move while busy
    p_cfg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({mode_q, wide_q, width_q, height_q, pitch_q, base_q, size_q, doff_q}));

endmodule

// File: tb/tile_copy_seq_bench.sv
`timescale 1ns/1ps
module tile_copy_seq_bench;

    localparam int AW    = 32;
    localparam int MEM_N = 2048;
    localparam logic [31:0] MASK = 32'(MEM_N - 1);

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, mode, px_wide;
    logic [15:0] img_width, img_height, pitch;
    logic [31:0] tile_base, tile_size, data_offset;
    logic        xl_req, xl_ack;
    logic [31:0] xl_addr, xl_tiled;
    logic        lin_en, lin_we, til_en, til_we, busy, done;
    logic [31:0] lin_addr, til_addr, lin_wdata, til_wdata, lin_rdata, til_rdata;
    logic [3:0]  lin_be, til_be;

    always #5 clk = ~clk;

    tile_copy_seq u_tile_copy_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .img_width(img_width), .img_height(img_height), .pitch(pitch),
        .px_wide(px_wide), .tile_base(tile_base), .tile_size(tile_size),
        .data_offset(data_offset), .xl_req(xl_req), .xl_addr(xl_addr),
        .xl_ack(xl_ack), .xl_tiled(xl_tiled),
        .lin_en(lin_en), .lin_we(lin_we), .lin_addr(lin_addr), .lin_be(lin_be),
        .lin_wdata(lin_wdata), .lin_rdata(lin_rdata),
        .til_en(til_en), .til_we(til_we), .til_addr(til_addr), .til_be(til_be),
        .til_wdata(til_wdata), .til_rdata(til_rdata),
        .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] lin_mem [0:MEM_N-1];
    logic [7:0] til_mem [0:MEM_N-1];
    logic [7:0] seed_lin [0:MEM_N-1];
    logic [7:0] seed_til [0:MEM_N-1];
    logic [7:0] exp_lin [0:MEM_N-1];
    logic [7:0] exp_til [0:MEM_N-1];
    logic [31:0] exp_xl [0:63];
    logic        load_mem = 1'b0;
    logic [31:0] cur_base = 32'h0;
    logic        cur_wide = 1'b0;

    function automatic logic [31:0] xlate(input logic [31:0] a, input logic [31:0] b);
        return b + ((a - b) ^ 32'h0000_0140);
    endfunction

    // Memory models: one-cycle read latency, byte lanes at address+k
    always @(posedge clk) begin
        if (load_mem) begin
            for (int i = 0; i < MEM_N; i++) begin
                lin_mem[i] <= seed_lin[i];
                til_mem[i] <= seed_til[i];
            end
        end else begin
            if (lin_en) begin
                for (int k = 0; k < 4; k++) begin
                    if (lin_we) begin
                        if (lin_be[k]) lin_mem[(lin_addr + 32'(k)) & MASK] <= lin_wdata[8*k +: 8];
                    end else begin
                        lin_rdata[8*k +: 8] <= lin_mem[(lin_addr + 32'(k)) & MASK];
                    end
                end
            end
            if (til_en) begin
                for (int k = 0; k < 4; k++) begin
                    if (til_we) begin
                        if (til_be[k]) til_mem[(til_addr + 32'(k)) & MASK] <= til_wdata[8*k +: 8];
                    end else begin
                        til_rdata[8*k +: 8] <= til_mem[(til_addr + 32'(k)) & MASK];
                    end
                end
            end
        end
    end

    // Translator model with random latency
    int wait_cnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            xl_ack   <= 1'b0;
            xl_tiled <= '0;
            wait_cnt <= 0;
        end else if (xl_req && !xl_ack) begin
            if (wait_cnt == 0) begin
                xl_ack   <= 1'b1;
                xl_tiled <= xlate(xl_addr, cur_base);
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end else begin
            xl_ack   <= 1'b0;
            wait_cnt <= int'($urandom % 3);
        end
    end

    // Monitor, sampling at the falling edge
    int xl_total = 0, xl_base = 0, xl_bad = 0, req_bad = 0;
    int wr_total = 0, be_bad = 0, done_seen = 0, done_bad = 0;
    logic prev_evt = 1'b0, prev_done = 1'b0, prev_wait = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (xl_req && xl_ack) begin
                if ((xl_total - xl_base) < 64 && xl_addr !== exp_xl[xl_total - xl_base]) xl_bad++;
                xl_total++;
            end
            if (prev_wait && !xl_req) req_bad++;
            if ((lin_en && lin_we) || (til_en && til_we)) wr_total++;
            if (lin_en && lin_be !== (cur_wide ? 4'hF : 4'h3)) be_bad++;
            if (til_en && til_be !== (cur_wide ? 4'hF : 4'h3)) be_bad++;
            if (done) begin
                done_seen++;
                if (!prev_evt || prev_done) done_bad++;
            end
            prev_evt  = ((lin_en && lin_we) || (til_en && til_we)) || (xl_req && xl_ack) || (start && !busy);
            prev_done = done;
            prev_wait = xl_req && !xl_ack;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_copy(input logic md, input int w, input int h, input int pt,
                            input logic wd, input logic [31:0] base, input logic [31:0] size,
                            input logic [31:0] doff, input bit inj);
        int bpp, exp_wr, n, mis_dst, mis_src, wr0, be0, dn0, db0, xb0, rb0, cyc;
        bpp = wd ? 4 : 2;
        exp_wr = 0; n = 0;
        for (int i = 0; i < MEM_N; i++) begin
            seed_lin[i] = 8'($urandom);
            seed_til[i] = 8'($urandom);
            exp_lin[i]  = seed_lin[i];
            exp_til[i]  = seed_til[i];
        end
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                logic [31:0] lo, a, rel, to;
                lo  = 32'(r * pt + c * bpp);
                a   = base + doff + lo;
                rel = xlate(a, base) - base;
                exp_xl[n] = a;
                n++;
                if (rel < size) begin
                    to = rel - doff;
                    exp_wr++;
                    for (int k = 0; k < bpp; k++) begin
                        if (!md) exp_til[(to + 32'(k)) & MASK] = seed_lin[(lo + 32'(k)) & MASK];
                        else     exp_lin[(lo + 32'(k)) & MASK] = seed_til[(to + 32'(k)) & MASK];
                    end
                end
            end
        end
        cur_base = base;
        cur_wide = wd;
        @(negedge clk); load_mem = 1'b1;
        @(negedge clk); load_mem = 1'b0;
        wr0 = wr_total; be0 = be_bad; dn0 = done_seen; db0 = done_bad; xb0 = xl_bad; rb0 = req_bad;
        xl_base = xl_total;
        mode = md; img_width = 16'(w); img_height = 16'(h); pitch = 16'(pt);
        px_wide = wd; tile_base = base; tile_size = size; data_offset = doff;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (inj) begin
            @(negedge clk);
            if (busy && !done) begin
                start = 1'b1; mode = ~md; img_width = 16'(w + 3); px_wide = ~wd;
                tile_base = base + 32'h40; tile_size = 32'h0; data_offset = doff + 32'h8;
                @(negedge clk); start = 1'b0; pitch = 16'(pt + 8);
            end
        end
        cyc = 0;
        while (done_seen == dn0 && cyc < 3000) begin
            @(negedge clk); cyc++;
        end
        chk("R7 run completes", 32'(done_seen - dn0), 32'd1);
        @(negedge clk);
        chk("R7 busy cleared after done", {31'd0, busy}, 32'd0);
        chk("R1 one request per pixel", 32'(xl_total - xl_base), 32'(w * h));
        chk("R1 request addresses", 32'(xl_bad - xb0), 32'd0);
        chk("R10 request held", 32'(req_bad - rb0), 32'd0);
        chk("R5 in-range write count", 32'(wr_total - wr0), 32'(exp_wr));
        chk("R4 byte enables", 32'(be_bad - be0), 32'd0);
        chk("R7 done placement", 32'(done_bad - db0), 32'd0);
        mis_dst = 0; mis_src = 0;
        for (int i = 0; i < MEM_N; i++) begin
            if (!md) begin
                if (til_mem[i] !== exp_til[i]) mis_dst++;
                if (lin_mem[i] !== exp_lin[i]) mis_src++;
            end else begin
                if (lin_mem[i] !== exp_lin[i]) mis_dst++;
                if (til_mem[i] !== exp_til[i]) mis_src++;
            end
        end
        if (!md) begin
            chk("R2 R6 tiled image after encode", 32'(mis_dst), 32'd0);
            chk("R2 linear buffer untouched", 32'(mis_src), 32'd0);
        end else begin
            chk("R3 linear image after decode", 32'(mis_dst), 32'd0);
            chk("R3 tiled buffer untouched", 32'(mis_src), 32'd0);
        end
        if (inj) chk("R8 mid-run start ignored", 32'(mis_dst + mis_src), 32'd0);
    endtask

    task automatic run_empty(input int w, input int h);
        int wr0;
        wr0 = wr_total;
        @(negedge clk);
        img_width = 16'(w); img_height = 16'(h); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R9 done in next cycle", {31'd0, done}, 32'd1);
        chk("R9 no request or strobe", {29'd0, xl_req, lin_en, til_en}, 32'd0);
        @(negedge clk);
        chk("R7 done cleared", {31'd0, done}, 32'd0);
        chk("R9 no writes", 32'(wr_total - wr0), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; mode = 1'b0; px_wide = 1'b0;
        img_width = '0; img_height = '0; pitch = '0;
        tile_base = '0; tile_size = '0; data_offset = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset idle", {27'd0, busy, done, xl_req, lin_en, til_en}, 32'd0);

        run_copy(1'b0, 1, 1, 4, 1'b0, 32'h0004_0000, 32'h400, 32'h0, 1'b0);
        run_copy(1'b1, 8, 8, 40, 1'b1, 32'h0004_0100, 32'h800, 32'h10, 1'b0);
        run_copy(1'b0, 5, 4, 24, 1'b1, 32'h0004_0200, 32'h0, 32'h8, 1'b0);
        run_copy(1'b1, 6, 3, 16, 1'b0, 32'h0004_0000, 32'hC0, 32'h4, 1'b0);
        run_copy(1'b0, 6, 5, 28, 1'b1, 32'h0004_0300, 32'h800, 32'h20, 1'b1);
        run_copy(1'b1, 7, 4, 16, 1'b0, 32'h0004_0000, 32'h800, 32'h0, 1'b1);
        run_empty(0, 5);
        run_empty(3, 0);
        run_empty(0, 0);

        for (int t = 0; t < 16; t++) begin
            int w, h, pt;
            logic wd, md;
            w  = 1 + int'($urandom % 8);
            h  = 1 + int'($urandom % 6);
            wd = 1'($urandom);
            md = 1'($urandom);
            pt = w * (wd ? 4 : 2) + 4 * int'($urandom % 4);
            run_copy(md, w, h, pt, wd,
                     32'h0004_0000 + 32'h100 * ($urandom % 8),
                     32'd128 + 32'd64 * ($urandom % 14),
                     32'd4 * ($urandom % 16), 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule